// File: doc/BRIEF.md
# Jittered Switching-Period Generator with Frequency Foldback

This block produces the gate drive for a fixed-frequency, current-mode flyback converter. A phase accumulator advances each clock by a step that sets the switching frequency. A carry out of the accumulator opens a new switching cycle and raises the drive. The drive falls when the current comparator signals the end of the pulse, when the on-time ceiling is reached, or when skip mode takes over. The feedback voltage arrives as an unsigned code in millivolts.

The feedback code sets three things. Above the upper foldback knee the block runs at the nominal rate, 65 kHz or 100 kHz, chosen by a parameter. Between the two knees the frequency falls linearly to a floor. Below the freeze level a flag tells the peak-current stage to hold its setpoint. A hysteretic comparator on the feedback code stops pulses entirely at very light load. A slow triangular modulation spreads the switching frequency by a few percent to soften the emission spectrum.

Top module: `pwm_fold_osc`

## Requirements
- R1: While `rst_n` is low, `drv_o`, `maxd_o`, `skip_o` and `freeze_o` are 0, the accumulator is 0 and the jitter triangle is at 0 and counting up.
- R2: On each clock with `en_i` high, the ACC_W-bit accumulator adds the step `inc` modulo 2^ACC_W. A carry out starts a switching cycle: `drv_o` goes to 1 at that edge, or to 0 if skip is active. The step for a frequency F is round(F*2^ACC_W/CLK_HZ).
- R3: The base step is S_NOM for a feedback code at or above FOLD_HI (2000) and S_MIN (27 kHz) at or below FOLD_LO (900). Between the two it is S_MIN + (((fb-FOLD_LO)*K) >> 12), where K = ((S_NOM-S_MIN) << 12)/(FOLD_HI-FOLD_LO), with integer division.
- R4: The jitter triangle moves by one every JIT_DIV = CLK_HZ/(JIT_HZ*4*JIT_STEPS) clocks. It runs between -JIT_STEPS and +JIT_STEPS and turns at each end. The applied step is inc = base + floor(base*t*J/2^16), where J = (JIT_PCT*2^16 + 50*JIT_STEPS)/(100*JIT_STEPS) and t is the triangle value before the edge.
- R5: The drive stays high for at most TON_MAX = floor(CLK_HZ/F_NOM)*80/100 clocks. When this limit ends a pulse, `maxd_o` is high for exactly the one cycle in which the drive falls.
- R6: `term_i` high at an edge while the drive is high (and no new cycle starts) drops the drive at that edge, and `maxd_o` stays low. `term_i` has no effect while the drive is low.
- R7: `skip_o` becomes 1 at the edge after the code is below SKIP_IN (700) and 0 at the edge after it is above SKIP_OUT (800). Otherwise it keeps its value.
- R8: While `skip_o` is 1, no new pulse starts, and a pulse in progress ends at the next edge.
- R9: `freeze_o` is registered as (fb < FREEZE, 1500) at every edge.
- R10: With `en_i` low, the accumulator is held at 0 and the drive falls at the next edge. The first pulse after enabling comes one full period later.
- R11: Parameter HI_FREQ selects the nominal frequency: 0 gives 65 kHz and 1 gives 100 kHz. TON_MAX and S_NOM are derived from the selected frequency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Switching enable |
| fb_i | input | FB_W | Feedback code in millivolts |
| term_i | input | 1 | Cycle-terminate pulse from the current comparator |
| drv_o | output | 1 | Gate drive |
| maxd_o | output | 1 | One-cycle flag: pulse ended by the on-time ceiling |
| freeze_o | output | 1 | Peak-current setpoint frozen |
| skip_o | output | 1 | Skip mode active |

## Verification
The feedback code is swept across both foldback knees and the freeze level. A step that was wrong at a knee, or ramped the wrong way, would move the measured period out of its window and break the per-clock match against the reference. Holding `term_i` high must produce one-clock pulses; a design that ignored it, or flagged those pulses as maximum duty, would show full-width pulses or a stray flag. The feedback code is parked between 700 and 800 mV on both sides of the hysteresis band. A design without memory there would drop skip on re-entry or start pulses. The run also covers a whole jitter triangle, so a wrong turning point or sign shows up as a period spread that is too small or offset.

// File: rtl/pwm_fold_pkg.sv
package pwm_fold_pkg;

    // direction of the jitter triangle
    typedef enum logic {
        SWING_UP   = 1'b0,
        SWING_DOWN = 1'b1
    } swing_dir_e;

    // accumulator step for a frequency, rounded to nearest
    function automatic longint phase_step(longint hz, longint clk_hz, int acc_w);
        return ((hz << acc_w) + clk_hz / 2) / clk_hz;
    endfunction

    // fixed-point jitter gain with 16 fractional bits
    function automatic longint jitter_gain(longint pct, longint steps);
        return (pct * 65536 + 50 * steps) / (100 * steps);
    endfunction

endpackage

// File: rtl/pwm_jitter_tri.sv
module pwm_jitter_tri #(
    parameter int CLK_HZ    = 50_000_000,
    parameter int JIT_HZ    = 125,
    parameter int JIT_STEPS = 32,
    localparam int TRI_W    = $clog2(JIT_STEPS + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic signed [TRI_W-1:0] swing_o
);
    import pwm_fold_pkg::*;

    localparam int JIT_DIV  = CLK_HZ / (JIT_HZ * 4 * JIT_STEPS);
    localparam int DIV_W    = $clog2(JIT_DIV + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(JIT_DIV - 1);
    localparam logic signed [TRI_W-1:0] TOP = TRI_W'(JIT_STEPS);
    localparam logic signed [TRI_W-1:0] BOT = -TRI_W'(JIT_STEPS);

    typedef struct packed {
        logic signed [TRI_W-1:0] swing;
        swing_dir_e              dir;
        logic [DIV_W-1:0]        div;
    } tri_st_t;

    tri_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.div == DIV_LAST) begin
            st_d.div = '0;
            if (st_q.dir == SWING_UP) begin
                st_d.swing = st_q.swing + TRI_W'(1);
                if (st_d.swing == TOP) st_d.dir = SWING_DOWN;
            end else begin
                st_d.swing = st_q.swing - TRI_W'(1);
                if (st_d.swing == BOT) st_d.dir = SWING_UP;
            end
        end else begin
            st_d.div = st_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.swing <= '0;
            st_q.dir   <= SWING_UP;
            st_q.div   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign swing_o = st_q.swing;

    // R4: the triangle never leaves its band
    assert_swing_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.swing <= TOP) && (st_q.swing >= BOT));

    // R4: the value moves only on a divider wrap, and by one
    assert_swing_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.div != DIV_LAST) |=> $stable(st_q.swing));

endmodule

// File: rtl/pwm_fold_map.sv
module pwm_fold_map #(
    parameter int CLK_HZ    = 50_000_000,
    parameter int NOM_HZ    = 65_000,
    parameter int FMIN_HZ   = 27_000,
    parameter int ACC_W     = 24,
    parameter int FB_W      = 12,
    parameter int FOLD_HI   = 2000,
    parameter int FOLD_LO   = 900,
    parameter int JIT_PCT   = 6,
    parameter int JIT_STEPS = 32,
    localparam int TRI_W    = $clog2(JIT_STEPS + 1) + 1
) (
    input  logic [FB_W-1:0]         fb_i,
    input  logic signed [TRI_W-1:0] swing_i,
    output logic [ACC_W-1:0]        inc_o
);
    import pwm_fold_pkg::*;

    localparam int     SL_SH   = 12;
    localparam int     JIT_SH  = 16;
    localparam int     MW      = 48;
    localparam longint INC_NOM = phase_step(longint'(NOM_HZ), longint'(CLK_HZ), ACC_W);
    localparam longint INC_MIN = phase_step(longint'(FMIN_HZ), longint'(CLK_HZ), ACC_W);
    localparam longint SLOPE   = ((INC_NOM - INC_MIN) << SL_SH) / longint'(FOLD_HI - FOLD_LO);
    localparam longint JIT_K   = jitter_gain(longint'(JIT_PCT), longint'(JIT_STEPS));

    logic [FB_W-1:0]        fb_off;
    logic [MW-1:0]          ramp;
    logic [MW-1:0]          base;
    logic signed [MW-1:0]   swing_x;
    logic signed [MW-1:0]   jit_prod;
    logic signed [MW-1:0]   jit;

    assign swing_x = {{(MW-TRI_W){swing_i[TRI_W-1]}}, swing_i};

    always_comb begin
        fb_off = fb_i - FB_W'(FOLD_LO);
        ramp   = (MW'(fb_off) * MW'(SLOPE)) >> SL_SH;
        if (fb_i >= FB_W'(FOLD_HI)) begin
            base = MW'(INC_NOM);
        end else if (fb_i <= FB_W'(FOLD_LO)) begin
            base = MW'(INC_MIN);
        end else begin
            base = MW'(INC_MIN) + ramp;
        end
        jit_prod = $signed(base) * swing_x * $signed(MW'(JIT_K));
        jit      = jit_prod >>> JIT_SH;
        inc_o    = ACC_W'(base + $unsigned(jit));
    end

endmodule

// File: rtl/pwm_skip_gate.sv
module pwm_skip_gate #(
    parameter int FB_W        = 12,
    parameter int FREEZE_MV   = 1500,
    parameter int SKIP_IN_MV  = 700,
    parameter int SKIP_OUT_MV = 800
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FB_W-1:0] fb_i,
    output logic            skip_o,
    output logic            freeze_o
);

    typedef struct packed {
        logic skip;
        logic freeze;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.freeze = (fb_i < FB_W'(FREEZE_MV));
        if (fb_i < FB_W'(SKIP_IN_MV)) begin
            st_d.skip = 1'b1;
        end else if (fb_i > FB_W'(SKIP_OUT_MV)) begin
            st_d.skip = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign skip_o   = st_q.skip;
    assign freeze_o = st_q.freeze;

    assert_skip_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_i < FB_W'(SKIP_IN_MV)) |=> skip_o);

    assert_skip_leave_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_i > FB_W'(SKIP_OUT_MV)) |=> !skip_o);

    // R7: inside the band the flag holds
    assert_skip_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((fb_i >= FB_W'(SKIP_IN_MV)) && (fb_i <= FB_W'(SKIP_OUT_MV))) |=> $stable(skip_o));

endmodule

// File: rtl/pwm_pulse_core.sv
module pwm_pulse_core #(
    parameter int ACC_W   = 24,
    parameter int TON_MAX = 615,
    localparam int TON_W  = $clog2(TON_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [ACC_W-1:0] inc_i,
    input  logic             term_i,
    input  logic             skip_i,
    output logic             drv_o,
    output logic             maxd_o
);

    localparam logic [TON_W-1:0] TON_LAST = TON_W'(TON_MAX - 1);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [TON_W-1:0] ton;
        logic             drv;
        logic             maxd;
    } core_st_t;

    core_st_t       st_d, st_q;
    logic [ACC_W:0] sum;

    always_comb begin
        st_d      = st_q;
        st_d.maxd = 1'b0;
        sum       = {1'b0, st_q.acc} + {1'b0, inc_i};
        if (!en_i) begin
            st_d.acc = '0;
            st_d.ton = '0;
            st_d.drv = 1'b0;
        end else begin
            st_d.acc = sum[ACC_W-1:0];
            if (sum[ACC_W]) begin
                // carry: a new switching cycle opens
                st_d.drv = !skip_i;
                st_d.ton = '0;
            end else if (st_q.drv) begin
                if (skip_i || term_i) begin
                    st_d.drv = 1'b0;
                end else if (st_q.ton == TON_LAST) begin
                    st_d.drv  = 1'b0;
                    st_d.maxd = 1'b1;
                end else begin
                    st_d.ton = st_q.ton + TON_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drv_o  = st_q.drv;
    assign maxd_o = st_q.maxd;

    // R5: the flag marks a pulse that was just cut at its ceiling
    assert_maxd_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        maxd_o |-> (!drv_o && $past(drv_o)));

    // R6: every falling drive edge has a cause
    assert_fall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_o) |-> ($past(term_i) || $past(skip_i) || !$past(en_i) || maxd_o));

    // R8: skip stops the drive by the next edge
    assert_skip_nodrive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        skip_i |=> !drv_o);

    // R10: disable stops the drive by the next edge
    assert_disable_nodrive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !drv_o);

endmodule

// File: rtl/pwm_fold_osc.sv
module pwm_fold_osc #(
    parameter int CLK_HZ      = 50_000_000,
    parameter bit HI_FREQ     = 1'b0,
    parameter int FMIN_HZ     = 27_000,
    parameter int MAXD_PCT    = 80,
    parameter int ACC_W       = 24,
    parameter int FB_W        = 12,
    parameter int FOLD_HI     = 2000,
    parameter int FOLD_LO     = 900,
    parameter int FREEZE_MV   = 1500,
    parameter int SKIP_IN_MV  = 700,
    parameter int SKIP_OUT_MV = 800,
    parameter int JIT_PCT     = 6,
    parameter int JIT_HZ      = 125,
    parameter int JIT_STEPS   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic [FB_W-1:0] fb_i,
    input  logic            term_i,
    output logic            drv_o,
    output logic            maxd_o,
    output logic            freeze_o,
    output logic            skip_o
);

    localparam int NOM_HZ  = HI_FREQ ? 100_000 : 65_000;
    localparam int NOM_PER = CLK_HZ / NOM_HZ;
    localparam int TON_MAX = NOM_PER * MAXD_PCT / 100;
    localparam int TRI_W   = $clog2(JIT_STEPS + 1) + 1;

    logic signed [TRI_W-1:0] swing;
    logic [ACC_W-1:0]        inc;
    logic                    skip;

    pwm_jitter_tri #(
        .CLK_HZ   (CLK_HZ),
        .JIT_HZ   (JIT_HZ),
        .JIT_STEPS(JIT_STEPS)
    ) u_jitter (
        .clk    (clk),
        .rst_n  (rst_n),
        .swing_o(swing)
    );

    pwm_fold_map #(
        .CLK_HZ   (CLK_HZ),
        .NOM_HZ   (NOM_HZ),
        .FMIN_HZ  (FMIN_HZ),
        .ACC_W    (ACC_W),
        .FB_W     (FB_W),
        .FOLD_HI  (FOLD_HI),
        .FOLD_LO  (FOLD_LO),
        .JIT_PCT  (JIT_PCT),
        .JIT_STEPS(JIT_STEPS)
    ) u_map (
        .fb_i   (fb_i),
        .swing_i(swing),
        .inc_o  (inc)
    );

    pwm_skip_gate #(
        .FB_W       (FB_W),
        .FREEZE_MV  (FREEZE_MV),
        .SKIP_IN_MV (SKIP_IN_MV),
        .SKIP_OUT_MV(SKIP_OUT_MV)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .fb_i    (fb_i),
        .skip_o  (skip),
        .freeze_o(freeze_o)
    );

    pwm_pulse_core #(
        .ACC_W  (ACC_W),
        .TON_MAX(TON_MAX)
    ) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_i),
        .inc_i (inc),
        .term_i(term_i),
        .skip_i(skip),
        .drv_o (drv_o),
        .maxd_o(maxd_o)
    );

    assign skip_o = skip;

endmodule

// File: tb/tb_pwm_fold_osc.sv
module tb_pwm_fold_osc;

    localparam int CLK_HZ    = 50_000_000;
    localparam int ACC_W     = 24;
    localparam int FB_W      = 12;
    localparam int JIT_HZ    = 2000;
    localparam int JIT_STEPS = 32;
    localparam int JIT_PCT   = 6;
    localparam longint F_NOM = 65000;
    localparam longint F_MIN = 27000;
    localparam int TON_MAX   = (CLK_HZ / 65000) * 80 / 100;
    localparam int JIT_DIV   = CLK_HZ / (JIT_HZ * 4 * JIT_STEPS);
    localparam longint S_NOM = ((F_NOM << ACC_W) + CLK_HZ / 2) / CLK_HZ;
    localparam longint S_MIN = ((F_MIN << ACC_W) + CLK_HZ / 2) / CLK_HZ;
    localparam longint K_FB  = ((S_NOM - S_MIN) << 12) / 1100;
    localparam longint J_GN  = (JIT_PCT * 65536 + 50 * JIT_STEPS) / (100 * JIT_STEPS);
    localparam longint MOD   = longint'(1) << ACC_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            en_i = 1'b0;
    logic [FB_W-1:0] fb_i = 12'd3000;
    logic            term_i = 1'b0;
    logic            drv_o, maxd_o, freeze_o, skip_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;

    pwm_fold_osc #(
        .CLK_HZ   (CLK_HZ),
        .HI_FREQ  (1'b0),
        .JIT_HZ   (JIT_HZ),
        .JIT_STEPS(JIT_STEPS)
    ) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .fb_i    (fb_i),
        .term_i  (term_i),
        .drv_o   (drv_o),
        .maxd_o  (maxd_o),
        .freeze_o(freeze_o),
        .skip_o  (skip_o)
    );

    // ---------------- reference model ----------------
    longint m_acc = 0;
    int     m_ton = 0;
    bit     m_drv = 0, m_maxd = 0, m_skip = 0, m_frz = 0;
    int     m_t = 0, m_div = 0;
    bit     m_down = 0;

    function automatic longint base_step(int fb);
        if (fb >= 2000) return S_NOM;
        if (fb <= 900)  return S_MIN;
        return S_MIN + ((longint'(fb - 900) * K_FB) >> 12);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_ton = 0; m_drv = 0; m_maxd = 0; m_skip = 0; m_frz = 0;
            m_t = 0; m_div = 0; m_down = 0;
        end else begin
            longint b, s, st;
            bit old_skip;
            b  = base_step(int'(fb_i));
            st = b + ((b * longint'(m_t) * J_GN) >>> 16);
            old_skip = m_skip;
            m_maxd = 0;
            if (!en_i) begin
                m_acc = 0; m_ton = 0; m_drv = 0;
            end else begin
                s = m_acc + st;
                m_acc = s % MOD;
                if (s >= MOD) begin
                    m_drv = !old_skip; m_ton = 0;
                end else if (m_drv) begin
                    if (old_skip || term_i) m_drv = 0;
                    else if (m_ton == TON_MAX - 1) begin m_drv = 0; m_maxd = 1; end
                    else m_ton++;
                end
            end
            if (fb_i < 700) m_skip = 1;
            else if (fb_i > 800) m_skip = 0;
            m_frz = (fb_i < 1500);
            if (m_div == JIT_DIV - 1) begin
                m_div = 0;
                if (!m_down) begin m_t++; if (m_t == JIT_STEPS) m_down = 1; end
                else begin m_t--; if (m_t == -JIT_STEPS) m_down = 0; end
            end else m_div++;
        end
    end

    // ---------------- checking and measurement ----------------
    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    longint cyc = 0, last_rise = -1, last_period = 0, width_run = 0, last_width = 0;
    int rises = 0, maxd_seen = 0;
    bit track = 0, prev_drv = 0;
    longint pmin = 1 << 30, pmax = 0;

    always @(negedge clk) begin
        cyc++;
        if (cmp_on) begin
            chk(drv_o == m_drv, "R2", "drv_o vs model", drv_o, m_drv);
            chk(maxd_o == m_maxd, "R5", "maxd_o vs model", maxd_o, m_maxd);
            chk(skip_o == m_skip, "R7", "skip_o vs model", skip_o, m_skip);
            chk(freeze_o == m_frz, "R9", "freeze_o vs model", freeze_o, m_frz);
        end
        if (maxd_o) maxd_seen++;
        if (drv_o && !prev_drv) begin
            rises++;
            if (last_rise >= 0) begin
                last_period = cyc - last_rise;
                if (track) begin
                    if (last_period < pmin) pmin = last_period;
                    if (last_period > pmax) pmax = last_period;
                end
            end
            last_rise = cyc;
            width_run = 1;
        end else if (drv_o) begin
            width_run++;
        end else if (prev_drv) begin
            last_width = width_run;
        end
        prev_drv = drv_o;
    end

    task automatic wait_rises(input int n);
        int target = rises + n;
        for (int i = 0; i < 30000 && rises < target; i++) @(negedge clk);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic period_in_window(input string req, input int fb);
        real p0, lo, hi;
        p0 = real'(MOD) / real'(base_step(fb));
        lo = p0 / 1.07 - 2.0;
        hi = p0 / 0.93 + 2.0;
        chk(real'(last_period) >= lo && real'(last_period) <= hi, req,
            "period in window", last_period, longint'(p0));
    endtask

    initial begin
        int r0;
        cycles(4);
        // R1: outputs at rest under reset
        chk(drv_o == 0, "R1", "drv_o in reset", drv_o, 0);
        chk(maxd_o == 0, "R1", "maxd_o in reset", maxd_o, 0);
        chk(skip_o == 0, "R1", "skip_o in reset", skip_o, 0);
        chk(freeze_o == 0, "R1", "freeze_o in reset", freeze_o, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        cycles(2);

        // R2, R11: nominal 65 kHz, R5: pulses cut at the ceiling
        en_i = 1'b1;
        wait_rises(4);
        cycles(TON_MAX + 4);
        chk(last_width == TON_MAX, "R5", "full pulse width", last_width, TON_MAX);
        chk(maxd_seen > 0, "R5", "max-duty flag seen", maxd_seen, 1);
        period_in_window("R11", 3000);

        // R6: terminate held high gives one-clock pulses, no flag
        term_i = 1'b1;
        r0 = maxd_seen;
        wait_rises(3);
        cycles(3);
        chk(last_width == 1, "R6", "terminated width", last_width, 1);
        chk(maxd_seen == r0, "R6", "no max-duty flag on terminate", maxd_seen, r0);
        term_i = 1'b0;

        // R4: period spread over one full triangle
        wait_rises(1);
        track = 1'b1;
        wait_rises(36);
        track = 1'b0;
        chk(pmax - pmin >= 50, "R4", "jitter spread", pmax - pmin, 50);
        chk(pmax - pmin <= 110, "R4", "jitter spread bound", pmax - pmin, 110);

        // R3, R9: foldback and freeze
        fb_i = 12'd1450;
        cycles(2);
        chk(freeze_o == 1, "R9", "freeze below 1500", freeze_o, 1);
        wait_rises(3);
        period_in_window("R3", 1450);
        fb_i = 12'd900;
        wait_rises(3);
        period_in_window("R3", 900);
        fb_i = 12'd1600;
        cycles(2);
        chk(freeze_o == 0, "R9", "freeze released", freeze_o, 0);
        wait_rises(2);

        // R7, R8: skip hysteresis
        fb_i = 12'd750;
        cycles(3);
        chk(skip_o == 0, "R7", "no skip entering band from above", skip_o, 0);
        fb_i = 12'd650;
        cycles(2);
        chk(skip_o == 1, "R7", "skip below 700", skip_o, 1);
        chk(drv_o == 0, "R8", "drive low in skip", drv_o, 0);
        fb_i = 12'd750;
        r0 = rises;
        cycles(4000);
        chk(skip_o == 1, "R7", "skip held inside band", skip_o, 1);
        chk(rises == r0, "R8", "no pulses in skip", rises, r0);
        fb_i = 12'd850;
        cycles(2);
        chk(skip_o == 0, "R7", "skip left above 800", skip_o, 0);
        r0 = rises;
        wait_rises(2);
        chk(rises >= r0 + 2, "R8", "pulses resume", rises, r0 + 2);

        // R10: disable
        fb_i = 12'd3000;
        en_i = 1'b0;
        cycles(2);
        chk(drv_o == 0, "R10", "drive low when disabled", drv_o, 0);
        r0 = rises;
        cycles(2000);
        chk(rises == r0, "R10", "no pulses when disabled", rises, r0);
        en_i = 1'b1;
        wait_rises(2);
        cycles(5);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 190000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule